// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block runs the byte-level handshake on the monitor (control) sub-channel of a time-multiplexed ISDN peripheral link. Once per 125 µs frame an upstream serializer presents the byte the controller sent, together with the controller's send flag and acknowledge flag, and pulses `frame_stb` for one clock. The block answers with its own acknowledge flag for the controller's bytes, plus its own send flag and byte for reply messages. All flags are active low: a 0 means active.

An incoming message opens with a chip-select byte. Its upper nibble must equal the strapped `dev_id`. The bytes after it alternate between a register address byte and a write data byte, so one message can write several registers. An address byte with bit 2 set is a read request. It produces a one-cycle `reg_re` strobe, and the register value returned on `reg_rdata` goes back to the controller as a one-byte reply message. A byte counts only when the same value is seen in two consecutive frames. A later byte whose two copies disagree is aborted, and the rest of that message is ignored. Register storage lives outside the block.

Top module: `mon_handshake_ctrl`

## Requirements
- R1: After synchronous reset, `tx_a_n` and `tx_e_n` are 1, `tx_byte` is all ones, and `reg_we` and `reg_re` are 0.
- R2: In idle, a byte with `rx_e_n`=0 becomes a candidate chip-select byte. When the identical byte arrives in the next frame and bits 7:4 equal `dev_id`, `tx_a_n` goes to 0 from the following frame on.
- R3: If a chip-select byte is validated with bits 7:4 different from `dev_id`, `tx_a_n` stays 1 and no register strobe occurs until `rx_e_n` has been 1 in two consecutive frames.
- R4: No abort is possible on the chip-select byte. Differing copies only replace the candidate. After validation, `tx_a_n` stays 0 for at least two frames unless a new byte is announced.
- R5: A later byte is announced by `rx_e_n`=1 for one frame and confirmed by `rx_e_n`=0 with the same byte in the next frame. `tx_a_n` then reads 1 for one frame (pre-acknowledge) and 0 in the frame after (acknowledge). An address byte with bit 2 clear followed by a data byte gives one `reg_we` pulse carrying both bytes.
- R6: If the confirming copy of a later byte differs from the announced one, `tx_a_n` reads 1 in both following frames and the byte is discarded. Further bytes are ignored until `rx_e_n` has been 1 in two consecutive frames.
- R7: `rx_e_n`=1 in two consecutive frames ends a message, with `tx_a_n` 1 from the next frame. The next message must again begin with a chip-select byte.
- R8: An address byte with bit 2 set gives one `reg_re` pulse with that byte on `reg_addr` and no write. The byte after it is again an address byte.
- R9: A reply starts (`tx_e_n` goes to 0, `tx_byte` holds the `reg_rdata` value taken at `reg_re`) only at a frame in which `rx_a_n` has been 1 for at least two consecutive frames, this frame included.
- R10: The reply is held until `rx_a_n`=0 is seen. One frame later `tx_e_n` returns to 1 and `tx_byte` to all ones, whether that frame acknowledges or aborts. An aborted reply is not sent again.
- R11: `tx_a_n`, `tx_e_n` and `tx_byte` change only on the clock after a `frame_stb`. `reg_we` and `reg_re` are single-cycle and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per frame; the rx inputs are valid in that cycle |
| dev_id | input | 4 | Strapped device address compared with chip-select bits 7:4 |
| rx_byte | input | 8 | Monitor byte received from the controller this frame |
| rx_e_n | input | 1 | Controller send flag, active low |
| rx_a_n | input | 1 | Controller acknowledge flag for replies, active low |
| tx_byte | output | 8 | Monitor byte sent by the block (all ones when idle) |
| tx_e_n | output | 1 | Block send flag for replies, active low |
| tx_a_n | output | 1 | Block acknowledge flag, active low |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register address byte for the current strobe |
| reg_wdata | output | 8 | Write data for `reg_we` |
| reg_rdata | input | 8 | Register contents, sampled while `reg_re` is high |

## Verification
The controller side is driven with scripted frame sequences covering several cases: a clean two-pair write, a chip-select byte whose copies first disagree, a foreign address, a later byte with mismatched copies, and read requests mixed with writes. Together these separate true validation from merely tracking the last byte, and separate abort handling from end-of-message handling. The reply path is tried with both an acknowledging and an aborting controller, which shows whether a reply is dropped or resent. A frame-level reference model in the bench predicts the flags and bytes and the queue of register strobes. The outputs are compared against it on every clock.

// File: rtl/mon_pkg.sv
package mon_pkg;
    localparam int unsigned MB_W   = 8;   // monitor byte width
    localparam int unsigned CS_W   = 4;   // chip-select id width
    localparam int unsigned RD_BIT = 2;   // read-request flag position in an address byte

    typedef logic [MB_W-1:0] mbyte_t;
    typedef logic [CS_W-1:0] devid_t;

    typedef enum logic [2:0] {
        RX_IDLE,   // no message
        RX_CS1,    // one copy of the chip-select byte held
        RX_HOLD,   // message open, acknowledge asserted
        RX_NEW1,   // new byte announced, waiting for its second copy
        RX_PRE,    // pre-acknowledge frame
        RX_QUIET   // message ignored, waiting for end
    } rx_st_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_WAIT,
        TX_GAP
    } tx_st_e;

    typedef struct packed {
        logic   first;
        logic   valid;
        mbyte_t data;
    } rx_evt_t;

    typedef struct packed {
        logic   we;
        logic   re;
        mbyte_t addr;
        mbyte_t wdata;
    } reg_cmd_t;

    function automatic logic cs_hit(mbyte_t b, devid_t id);
        return b[MB_W-1 -: CS_W] == id;
    endfunction

    function automatic logic is_read(mbyte_t b);
        return b[RD_BIT];
    endfunction
endpackage

// File: rtl/mon_rx.sv
module mon_rx
    import mon_pkg::*;
#(
    parameter int unsigned QUIET_FRAMES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_stb,
    input  mbyte_t  rx_byte,
    input  logic    rx_e_n,
    input  devid_t  dev_id,
    output logic    a_n,
    output rx_evt_t evt
);
    localparam int unsigned QW = $clog2(QUIET_FRAMES + 1);

    rx_st_e        st;
    mbyte_t        cand;
    logic          pre_ok;
    logic [QW-1:0] qcnt;
    logic          same;
    logic          e_off;

    assign same  = (rx_byte == cand);
    assign e_off = rx_e_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            cand   <= '0;
            pre_ok <= 1'b0;
            qcnt   <= '0;
            a_n    <= 1'b1;
            evt    <= '0;
        end else begin
            evt <= '0;
            if (frame_stb) begin
                case (st)
                    RX_IDLE: begin
                        a_n <= 1'b1;
                        if (!e_off) begin
                            cand <= rx_byte;
                            st   <= RX_CS1;
                        end
                    end
                    RX_CS1: begin
                        if (e_off) begin
                            st <= RX_IDLE;
                        end else if (!same) begin
                            cand <= rx_byte;
                        end else if (cs_hit(rx_byte, dev_id)) begin
                            a_n       <= 1'b0;
                            evt.first <= 1'b1;
                            st        <= RX_HOLD;
                        end else begin
                            qcnt <= '0;
                            st   <= RX_QUIET;
                        end
                    end
                    RX_HOLD: begin
                        if (e_off) begin
                            cand <= rx_byte;
                            st   <= RX_NEW1;
                        end
                    end
                    RX_NEW1: begin
                        a_n <= 1'b1;
                        if (e_off) begin
                            st <= RX_IDLE;
                        end else begin
                            pre_ok    <= same;
                            evt.valid <= same;
                            evt.data  <= rx_byte;
                            st        <= RX_PRE;
                        end
                    end
                    RX_PRE: begin
                        if (pre_ok) begin
                            a_n <= 1'b0;
                            if (e_off) begin
                                cand <= rx_byte;
                                st   <= RX_NEW1;
                            end else begin
                                st <= RX_HOLD;
                            end
                        end else begin
                            a_n  <= 1'b1;
                            qcnt <= e_off ? QW'(1) : '0;
                            st   <= RX_QUIET;
                        end
                    end
                    RX_QUIET: begin
                        a_n <= 1'b1;
                        if (e_off) begin
                            if (int'(qcnt) + 1 >= int'(QUIET_FRAMES)) begin
                                st <= RX_IDLE;
                            end else begin
                                qcnt <= qcnt + 1'b1;
                            end
                        end else begin
                            qcnt <= '0;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mon_decode.sv
module mon_decode
    import mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_evt_t  evt,
    output reg_cmd_t cmd
);
    logic want_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            want_addr <= 1'b1;
            cmd       <= '0;
        end else begin
            cmd.we <= 1'b0;
            cmd.re <= 1'b0;
            if (evt.first) begin
                want_addr <= 1'b1;
            end else if (evt.valid) begin
                if (want_addr) begin
                    cmd.addr <= evt.data;
                    if (is_read(evt.data)) begin
                        cmd.re <= 1'b1;
                    end else begin
                        want_addr <= 1'b0;
                    end
                end else begin
                    cmd.wdata <= evt.data;
                    cmd.we    <= 1'b1;
                    want_addr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mon_tx.sv
module mon_tx
    import mon_pkg::*;
#(
    parameter int unsigned QUIET_FRAMES = 2,
    parameter int unsigned GAP_FRAMES   = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_stb,
    input  logic   rx_a_n,
    input  logic   load,
    input  mbyte_t load_data,
    output logic   e_n,
    output mbyte_t byte_o
);
    localparam int unsigned QW = $clog2(QUIET_FRAMES + 1);
    localparam int unsigned GW = $clog2(GAP_FRAMES + 1);

    tx_st_e        st;
    logic          pend;
    mbyte_t        buf_q;
    logic [QW-1:0] qa;
    logic [GW-1:0] gcnt;
    logic          a_quiet;

    assign a_quiet = rx_a_n && (int'(qa) + 1 >= int'(QUIET_FRAMES));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_IDLE;
            pend   <= 1'b0;
            buf_q  <= '0;
            qa     <= '0;
            gcnt   <= '0;
            e_n    <= 1'b1;
            byte_o <= '1;
        end else begin
            if (frame_stb) begin
                if (!rx_a_n) begin
                    qa <= '0;
                end else if (int'(qa) < int'(QUIET_FRAMES)) begin
                    qa <= qa + 1'b1;
                end
                case (st)
                    TX_IDLE: begin
                        if (pend && a_quiet) begin
                            e_n    <= 1'b0;
                            byte_o <= buf_q;
                            pend   <= 1'b0;
                            st     <= TX_SEND;
                        end
                    end
                    TX_SEND: begin
                        if (!rx_a_n) st <= TX_WAIT;
                    end
                    TX_WAIT: begin
                        e_n    <= 1'b1;
                        byte_o <= '1;
                        gcnt   <= '0;
                        st     <= TX_GAP;
                    end
                    TX_GAP: begin
                        if (int'(gcnt) + 1 >= int'(GAP_FRAMES)) begin
                            st <= TX_IDLE;
                        end else begin
                            gcnt <= gcnt + 1'b1;
                        end
                    end
                    default: st <= TX_IDLE;
                endcase
            end
            if (load) begin
                pend  <= 1'b1;
                buf_q <= load_data;
            end
        end
    end
endmodule

// File: rtl/mon_handshake_ctrl.sv
module mon_handshake_ctrl
    import mon_pkg::*;
#(
    parameter int unsigned QUIET_FRAMES = 2,
    parameter int unsigned GAP_FRAMES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [CS_W-1:0]  dev_id,
    input  logic [MB_W-1:0]  rx_byte,
    input  logic             rx_e_n,
    input  logic             rx_a_n,
    output logic [MB_W-1:0]  tx_byte,
    output logic             tx_e_n,
    output logic             tx_a_n,
    output logic             reg_we,
    output logic             reg_re,
    output logic [MB_W-1:0]  reg_addr,
    output logic [MB_W-1:0]  reg_wdata,
    input  logic [MB_W-1:0]  reg_rdata
);
    rx_evt_t  evt;
    reg_cmd_t cmd;

    mon_rx #(.QUIET_FRAMES(QUIET_FRAMES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .rx_byte   (rx_byte),
        .rx_e_n    (rx_e_n),
        .dev_id    (dev_id),
        .a_n       (tx_a_n),
        .evt       (evt)
    );

    mon_decode u_dec (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .cmd (cmd)
    );

    mon_tx #(.QUIET_FRAMES(QUIET_FRAMES), .GAP_FRAMES(GAP_FRAMES)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .rx_a_n    (rx_a_n),
        .load      (cmd.re),
        .load_data (reg_rdata),
        .e_n       (tx_e_n),
        .byte_o    (tx_byte)
    );

    assign reg_we    = cmd.we;
    assign reg_re    = cmd.re;
    assign reg_addr  = cmd.addr;
    assign reg_wdata = cmd.wdata;
endmodule

// File: rtl/mon_handshake_chk.sv
module mon_handshake_chk
    import mon_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_stb,
    input logic             rx_a_n,
    input logic [MB_W-1:0]  tx_byte,
    input logic             tx_e_n,
    input logic             tx_a_n,
    input logic             reg_we,
    input logic             reg_re,
    input logic [MB_W-1:0]  reg_addr
);
    // R11: register strobes exclusive and one cycle wide
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re}));
    p_we_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);
    p_re_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);
    // R11: line outputs move only right after a frame strobe
    p_frame_sync_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_stb) |-> ($stable(tx_a_n) && $stable(tx_e_n) && $stable(tx_byte)));
    // R5: a register strobe falls in the pre-acknowledge frame
    p_cmd_preack_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) |-> tx_a_n);
    // R8: read strobes carry the read flag, writes never do
    p_read_flag_r8: assert property (@(posedge clk) disable iff (rst)
        reg_re |-> reg_addr[RD_BIT]);
    p_write_flag_r8: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !reg_addr[RD_BIT]);
    // R9: a reply starts only on a frame with the controller acknowledge idle
    p_reply_start_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_e_n) |-> ($past(frame_stb) && $past(rx_a_n)));
endmodule

bind mon_handshake_ctrl mon_handshake_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .rx_a_n    (rx_a_n),
    .tx_byte   (tx_byte),
    .tx_e_n    (tx_e_n),
    .tx_a_n    (tx_a_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr)
);

// File: tb/mon_handshake_ctrl_test.sv
`timescale 1ns/1ps
module mon_handshake_ctrl_test;
    localparam int FRAME_CLKS = 6;
    localparam logic [3:0] DEV = 4'hA;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_byte = 8'hFF;
    logic       rx_e_n = 1'b1;
    logic       rx_a_n = 1'b1;
    logic [7:0] tx_byte;
    logic       tx_e_n, tx_a_n, reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    assign reg_rdata = reg_addr ^ 8'hA5;

    always #2 clk = ~clk;

    mon_handshake_ctrl uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .dev_id(DEV),
        .rx_byte(rx_byte), .rx_e_n(rx_e_n), .rx_a_n(rx_a_n),
        .tx_byte(tx_byte), .tx_e_n(tx_e_n), .tx_a_n(tx_a_n),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int compared = 0;
    int mismatched = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    // reference model state
    logic       exp_a = 1'b1, exp_e = 1'b1;
    logic [7:0] exp_byte = 8'hFF;
    int         rmode = 0, tmode = 0, quiet = 0, acnt = 0, gcnt = 0;
    logic [7:0] cand = 8'h00, addr_q = 8'h00, bufv = 8'h00;
    bit         okf = 1'b0, want_addr = 1'b1, pend = 1'b0;
    logic [15:0] wq[$];
    logic [7:0]  rq[$];
    int nwr = 0, nrd = 0;
    bit a_went_low = 1'b0;

    task automatic ck(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void accept(input logic [7:0] b);
        if (want_addr) begin
            addr_q = b;
            if (b[2]) begin
                rq.push_back(b);
                pend = 1'b1;
                bufv = b ^ 8'hA5;
            end else begin
                want_addr = 1'b0;
            end
        end else begin
            wq.push_back({addr_q, b});
            want_addr = 1'b1;
        end
    endfunction

    function automatic void model_step(input logic e, input logic [7:0] b, input logic ra);
        acnt = ra ? acnt + 1 : 0;
        case (tmode)
            0: if (pend && acnt >= 2) begin exp_e = 1'b0; exp_byte = bufv; pend = 1'b0; tmode = 1; end
            1: if (!ra) tmode = 2;
            2: begin exp_e = 1'b1; exp_byte = 8'hFF; gcnt = 0; tmode = 3; end
            default: begin gcnt++; if (gcnt >= 2) tmode = 0; end
        endcase
        case (rmode)
            0: begin exp_a = 1'b1; if (!e) begin cand = b; rmode = 1; end end
            1: begin
                if (e) rmode = 0;
                else if (b != cand) cand = b;
                else if (b[7:4] == DEV) begin exp_a = 1'b0; want_addr = 1'b1; rmode = 2; end
                else begin quiet = 0; rmode = 5; end
            end
            2: if (e) begin cand = b; rmode = 3; end
            3: begin
                exp_a = 1'b1;
                if (e) rmode = 0;
                else begin okf = (b == cand); if (okf) accept(b); rmode = 4; end
            end
            4: begin
                if (okf) begin
                    exp_a = 1'b0;
                    if (e) begin cand = b; rmode = 3; end else rmode = 2;
                end else begin
                    exp_a = 1'b1; quiet = e ? 1 : 0; rmode = 5;
                end
            end
            default: begin
                exp_a = 1'b1;
                if (e) begin quiet++; if (quiet >= 2) rmode = 0; end
                else quiet = 0;
            end
        endcase
    endfunction

    // one frame: inputs set away from the edge, model advanced at the strobe edge
    task automatic fr(input logic e, input logic [7:0] b, input logic ra = 1'b1);
        @(negedge clk);
        rx_e_n = e; rx_byte = b; rx_a_n = ra; frame_stb = 1'b1;
        @(posedge clk);
        model_step(e, b, ra);
        @(negedge clk);
        frame_stb = 1'b0;
        repeat (FRAME_CLKS - 2) @(negedge clk);
    endtask

    // per-clock comparison against the model
    logic stb_q = 1'b0;
    logic pa = 1'b1, pe = 1'b1, pwe = 1'b0;
    always @(posedge clk) stb_q <= frame_stb;

    always @(negedge clk) begin
        if (running && !rst) begin
            ck("R4 tx_a_n", tx_a_n, exp_a);
            ck("R9 tx_e_n", tx_e_n, exp_e);
            ck("R10 tx_byte", tx_byte, exp_byte);
            if (!tx_a_n) a_went_low = 1'b1;
            ck("R11 flag change off-frame", int'(!stb_q && (tx_a_n != pa || tx_e_n != pe)), 0);
            ck("R11 strobe width", int'(pwe && reg_we), 0);
            ck("R11 strobe overlap", int'(reg_we && reg_re), 0);
            if (reg_we) begin
                nwr++;
                if (wq.size() == 0) ck("R5 unexpected write", 1, 0);
                else ck("R5 write addr/data", {reg_addr, reg_wdata}, wq.pop_front());
            end
            if (reg_re) begin
                nrd++;
                if (rq.size() == 0) ck("R8 unexpected read", 1, 0);
                else ck("R8 read addr", reg_addr, rq.pop_front());
            end
        end
        pa = tx_a_n; pe = tx_e_n; pwe = reg_we;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int w0;
        repeat (4) @(negedge clk);
        ck("R1 tx_a_n", tx_a_n, 1);
        ck("R1 tx_e_n", tx_e_n, 1);
        ck("R1 tx_byte", tx_byte, 8'hFF);
        ck("R1 strobes", {reg_we, reg_re}, 0);
        rst = 1'b0;
        running = 1'b1;
        repeat (3) fr(1'b1, 8'hFF);

        // clean two-pair write message
        fr(1'b0, 8'hA3);
        ck("R2 no ack on single copy", tx_a_n, 1);
        fr(1'b0, 8'hA3);
        ck("R2 ack after matching copy", tx_a_n, 0);
        fr(1'b1, 8'h09);
        ck("R4 ack held second frame", tx_a_n, 0);
        fr(1'b0, 8'h09);
        ck("R5 pre-ack", tx_a_n, 1);
        fr(1'b1, 8'h5C);
        ck("R5 ack", tx_a_n, 0);
        fr(1'b0, 8'h5C);
        fr(1'b1, 8'h11);
        fr(1'b0, 8'h11);
        fr(1'b1, 8'h77);
        fr(1'b0, 8'h77);
        fr(1'b1, 8'hFF);
        fr(1'b1, 8'hFF);
        ck("R7 A released at end", tx_a_n, 1);
        ck("R5 two writes", nwr, 2);

        // foreign chip-select
        w0 = nwr; a_went_low = 1'b0;
        fr(1'b0, 8'h53); fr(1'b0, 8'h53);
        fr(1'b1, 8'h09); fr(1'b0, 8'h09);
        fr(1'b1, 8'h66); fr(1'b0, 8'h66);
        fr(1'b1, 8'hFF); fr(1'b1, 8'hFF);
        ck("R3 no acknowledge", a_went_low, 0);
        ck("R3 no writes", nwr, w0);

        // first byte copies disagree: no abort, candidate replaced
        fr(1'b0, 8'hA1);
        fr(1'b0, 8'hA7);
        ck("R4 no ack on differing copies", tx_a_n, 1);
        fr(1'b0, 8'hA7);
        ck("R4 ack after third frame", tx_a_n, 0);
        fr(1'b0, 8'hA7);
        ck("R4 ack held", tx_a_n, 0);
        fr(1'b1, 8'h21); fr(1'b0, 8'h21);
        fr(1'b1, 8'h3E); fr(1'b0, 8'h3E);
        fr(1'b1, 8'hFF); fr(1'b1, 8'hFF);
        ck("R7 write after restart", nwr, w0 + 1);

        // abort on a later byte
        w0 = nwr;
        fr(1'b0, 8'hA0); fr(1'b0, 8'hA0);
        fr(1'b1, 8'h09);
        fr(1'b0, 8'h0B);
        ck("R6 pre-ack on mismatch", tx_a_n, 1);
        fr(1'b1, 8'h5C);
        ck("R6 abort frame", tx_a_n, 1);
        fr(1'b0, 8'h5C);
        fr(1'b1, 8'h42); fr(1'b0, 8'h42);
        ck("R6 ignored after abort", tx_a_n, 1);
        fr(1'b1, 8'hFF); fr(1'b1, 8'hFF);
        ck("R6 no write", nwr, w0);

        // read then write in one message, reply acknowledged
        w0 = nwr;
        fr(1'b0, 8'hA3); fr(1'b0, 8'hA3);
        fr(1'b1, 8'h0C); fr(1'b0, 8'h0C);
        fr(1'b1, 8'h19); fr(1'b0, 8'h19);
        ck("R9 reply started", tx_e_n, 0);
        ck("R9 reply byte", tx_byte, 8'h0C ^ 8'hA5);
        fr(1'b1, 8'hC4); fr(1'b0, 8'hC4);
        fr(1'b1, 8'hFF, 1'b0);
        ck("R10 held on pre-ack frame", tx_e_n, 0);
        fr(1'b1, 8'hFF, 1'b0);
        ck("R10 released after ack", tx_e_n, 1);
        ck("R8 read count", nrd, 1);
        ck("R8 write after read", nwr, w0 + 1);
        repeat (3) fr(1'b1, 8'hFF);

        // read with aborted reply
        fr(1'b0, 8'hAF); fr(1'b0, 8'hAF);
        fr(1'b1, 8'h2C); fr(1'b0, 8'h2C);
        fr(1'b1, 8'hFF); fr(1'b1, 8'hFF);
        ck("R9 second reply", tx_byte, 8'h2C ^ 8'hA5);
        fr(1'b1, 8'hFF, 1'b0);
        fr(1'b1, 8'hFF, 1'b1);
        ck("R10 stop after abort", tx_e_n, 1);
        repeat (6) begin
            fr(1'b1, 8'hFF);
            ck("R10 not resent", tx_e_n, 1);
        end
        ck("R5 write queue drained", wq.size(), 0);
        ck("R8 read queue drained", rq.size(), 0);

        running = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule